// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Unit

This block gathers event pulses from several ports of a cell receiver and transmitter and merges them into one active-low interrupt line. Each port has a status register and a mask register. A single-cycle event pulse on a source sets a sticky status bit. A mask bit of 1 lets that bit take part in the interrupt, and a mask bit of 0 blocks it. The status bit is recorded in every case, and the mask only gates the interrupt.

A control register holds two bits. The enable bit gates all signalling. The restrict bit limits signalling to the receive cell error sources, which are a bad header check, a short cell and a symbol error. Software reads a port's status register to find the cause. That read returns the bits and clears them in the same access, so the interrupt line is released unless another port is still pending. An event that arrives in the same cycle as the clearing read is kept, so no event is lost.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, int_n_o is 1, rdata_o is 0, and the control, status and mask registers all read 0.
- R2: A 1 on event bit s of port p at a clock edge sets status bit s of port p. The bit stays set until that port's status register is read.
- R3: Status bits are recorded even when they are masked or signalling is disabled.
- R4: A read (rd_i=1) places the register value on rdata_o one cycle later, and rdata_o holds that value until the next read. A read of a status register clears that port's status bits only.
- R5: An event that arrives in the same cycle as a clearing read of its port stays set after the read.
- R6: int_n_o is a registered output. It is 0 exactly when the enable bit is set and at least one status bit is set with its mask bit at 1 (and, in restrict mode, the bit is a receive cell error source). It reflects register updates made at the same edge.
- R7: With the control enable bit (bit 0) at 0, int_n_o stays 1 whatever the status bits hold.
- R8: With the control restrict bit (bit 5) at 1, only status bits 0 (bad header check), 1 (short cell) and 2 (symbol error) can drive int_n_o low.
- R9: A mask bit of 0 stops its status bit from driving int_n_o low.
- R10: Writes to a status register are ignored. Mask registers read back their written value. The control register reads back only bits 0 and 5.
- R11: The address map is: 0 for control, 1 to 3 for the status of ports 0 to 2, and 4 to 6 for the masks of ports 0 to 2. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 24 | One-cycle event pulses, 8 sources per port, port p at bits 8p+7..8p |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| int_n_o | output | 1 | Interrupt request, active low, registered |

## Verification
If the status or mask storage goes wrong, int_n_o shows it on the edge right after the event or the write, because the interrupt is computed from the updated state. The next read of that port also shows it on rdata_o. A wrong clear, such as one that hits the wrong port or drops a concurrent event, appears on the following read of the affected port. The int_n_o line can also expose it earlier, by staying low or rising too soon. The bench keeps a behavioural model and compares both outputs on every cycle, so any divergence is reported within one clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_BIT = 5;

    typedef struct packed {
        logic en;
        logic rx_only;
    } ctrl_t;
endpackage

// File: rtl/irq_port_bank.sv
module irq_port_bank #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_i,
    input  logic          clr_i,
    input  logic          mask_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] sta_q_o,
    output logic [DW-1:0] msk_q_o,
    output logic [DW-1:0] sta_d_o,
    output logic [DW-1:0] msk_d_o
);
    typedef struct packed {
        logic [DW-1:0] sta;
        logic [DW-1:0] msk;
    } bank_t;

    bank_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.sta = evt_i;
        else       st_d.sta = st_q.sta | evt_i;
        if (mask_we_i) st_d.msk = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sta_q_o = st_q.sta;
    assign msk_q_o = st_q.msk;
    assign sta_d_o = st_d.sta;
    assign msk_d_o = st_d.msk;

    // R2: without a clear, no set bit falls
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.sta & $past(st_q.sta)) == $past(st_q.sta)));
    // R3: an event is recorded whatever the mask holds
    assert_event_recorded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.sta & $past(evt_i)) == $past(evt_i)));
    // R5: after a clear only the concurrent events remain
    assert_clear_keeps_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.sta == $past(evt_i)));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int            NPORT      = 3,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] RX_ERR_SRC = 8'h07
) (
    input  logic [NPORT*DW-1:0] sta_i,
    input  logic [NPORT*DW-1:0] msk_i,
    input  logic                en_i,
    input  logic                rx_only_i,
    output logic                req_o
);
    logic [DW-1:0] sel;
    logic          any;

    always_comb begin
        sel = rx_only_i ? RX_ERR_SRC : '1;
        any = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            any = any | (|(sta_i[p*DW +: DW] & msk_i[p*DW +: DW] & sel));
        end
        req_o = en_i & any;
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int            NPORT      = 3,
    parameter int            DW         = 8,
    parameter int            AW         = 3,
    parameter logic [DW-1:0] RX_ERR_SRC = 8'h07
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT*DW-1:0] evt_i,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    output logic [DW-1:0]       rdata_o,
    output logic                int_n_o
);
    import irq_pkg::*;

    localparam int CTRL_ADDR = 0;
    localparam int STA_BASE  = 1;
    localparam int MSK_BASE  = STA_BASE + NPORT;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] rdata;
        logic          int_n;
    } top_t;

    top_t st_q, st_d;

    logic [NPORT-1:0]    sta_clr, msk_we;
    logic [NPORT*DW-1:0] sta_q, msk_q, sta_d, msk_d;
    logic                req_d, req_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign sta_clr[p] = rd_i && (addr_i == AW'(STA_BASE + p));
        assign msk_we[p]  = wr_i && (addr_i == AW'(MSK_BASE + p));

        irq_port_bank #(.DW(DW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[p*DW +: DW]),
            .clr_i     (sta_clr[p]),
            .mask_we_i (msk_we[p]),
            .wdata_i   (wdata_i),
            .sta_q_o   (sta_q[p*DW +: DW]),
            .msk_q_o   (msk_q[p*DW +: DW]),
            .sta_d_o   (sta_d[p*DW +: DW]),
            .msk_d_o   (msk_d[p*DW +: DW])
        );
    end

    irq_merge #(.NPORT(NPORT), .DW(DW), .RX_ERR_SRC(RX_ERR_SRC)) u_merge_d (
        .sta_i     (sta_d),
        .msk_i     (msk_d),
        .en_i      (st_d.ctrl.en),
        .rx_only_i (st_d.ctrl.rx_only),
        .req_o     (req_d)
    );

    irq_merge #(.NPORT(NPORT), .DW(DW), .RX_ERR_SRC(RX_ERR_SRC)) u_merge_q (
        .sta_i     (sta_q),
        .msk_i     (msk_q),
        .en_i      (st_q.ctrl.en),
        .rx_only_i (st_q.ctrl.rx_only),
        .req_o     (req_q)
    );

    always_comb begin
        logic [DW-1:0] rv;
        st_d = st_q;
        if (wr_i && addr_i == AW'(CTRL_ADDR)) begin
            st_d.ctrl.en      = wdata_i[CTRL_EN_BIT];
            st_d.ctrl.rx_only = wdata_i[CTRL_MODE_BIT];
        end
        rv = '0;
        if (addr_i == AW'(CTRL_ADDR)) begin
            rv[CTRL_EN_BIT]   = st_q.ctrl.en;
            rv[CTRL_MODE_BIT] = st_q.ctrl.rx_only;
        end
        for (int p = 0; p < NPORT; p++) begin
            if (addr_i == AW'(STA_BASE + p)) rv = sta_q[p*DW +: DW];
            if (addr_i == AW'(MSK_BASE + p)) rv = msk_q[p*DW +: DW];
        end
        if (rd_i) st_d.rdata = rv;
        st_d.int_n = !req_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.int_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign int_n_o = st_q.int_n;

    // R6: the registered line agrees with the stored state
    assert_int_matches_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_n_o == !req_q);
    // R7: disabled means never asserted
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |-> int_n_o);
    // R8: in restrict mode an asserted line needs a pending receive error
    assert_rx_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n_o && st_q.ctrl.rx_only) |-> (|(sta_q & msk_q & {NPORT{RX_ERR_SRC}})));
    // R4: read data only moves after a read
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        int_n;
    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .int_n_o(int_n)
    );

    // behavioural reference model
    logic [7:0] m_ctrl, m_rd;
    logic [7:0] m_sta [3];
    logic [7:0] m_msk [3];
    logic       m_int_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_rd = 0; m_int_n = 1;
            for (int p = 0; p < 3; p++) begin m_sta[p] = 0; m_msk[p] = 0; end
        end else begin
            logic [7:0] v;
            logic hit;
            v = 0;
            if (addr == 0) v = m_ctrl;
            else if (addr >= 1 && addr <= 3) v = m_sta[addr - 1];
            else if (addr >= 4 && addr <= 6) v = m_msk[addr - 4];
            if (rd) m_rd = v;
            for (int p = 0; p < 3; p++) begin
                if (rd && addr == 3'(p + 1)) m_sta[p] = evt[p*8 +: 8];
                else m_sta[p] = m_sta[p] | evt[p*8 +: 8];
                if (wr && addr == 3'(p + 4)) m_msk[p] = wdata;
            end
            if (wr && addr == 0) m_ctrl = wdata & 8'h21;
            hit = 0;
            for (int p = 0; p < 3; p++)
                if ((m_sta[p] & m_msk[p] & (m_ctrl[5] ? 8'h07 : 8'hFF)) != 0) hit = 1;
            m_int_n = !(m_ctrl[0] && hit);
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (cmp_on) begin
        chk("R6 int_n vs model", {7'b0, int_n}, {7'b0, m_int_n});
        chk("R4 rdata vs model", rdata, m_rd);
    end

    task automatic cyc(bit r, bit w, logic [2:0] a, logic [7:0] d, logic [23:0] e);
        rd = r; wr = w; addr = a; wdata = d; evt = e;
        @(negedge clk);
        rd = 0; wr = 0; evt = '0;
    endtask

    task automatic rread(logic [2:0] a, output logic [7:0] v);
        cyc(1, 0, a, 0, 0);
        v = rdata;
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        chk("R1 int_n reset", {7'b0, int_n}, 8'h01);
        chk("R1 rdata reset", rdata, 8'h00);
        for (int a = 0; a < 7; a++) begin
            rread(3'(a), v); chk("R1 register reset", v, 8'h00);
        end
        // masked event recorded but silent
        cyc(0, 1, 0, 8'h01, 0);
        cyc(0, 0, 0, 0, 24'h000008);
        chk("R9 masked keeps int_n high", {7'b0, int_n}, 8'h01);
        rread(1, v); chk("R3 masked event recorded", v, 8'h08);
        rread(1, v); chk("R4 read cleared", v, 8'h00);
        // unmasked event on port 1
        cyc(0, 1, 5, 8'hFF, 0);
        cyc(0, 0, 0, 0, 24'h001000);
        chk("R6 int_n low after event", {7'b0, int_n}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R2 sticky int_n", {7'b0, int_n}, 8'h00);
        rread(1, v); chk("R4 other port read", v, 8'h00);
        chk("R4 other port keeps int", {7'b0, int_n}, 8'h00);
        rread(2, v); chk("R2 port1 status", v, 8'h10);
        chk("R4 read releases int_n", {7'b0, int_n}, 8'h01);
        // restrict mode
        cyc(0, 1, 0, 8'h21, 0);
        cyc(0, 1, 6, 8'hFF, 0);
        cyc(0, 0, 0, 0, 24'h400000);
        chk("R8 non-rx source blocked", {7'b0, int_n}, 8'h01);
        cyc(0, 0, 0, 0, 24'h020000);
        chk("R8 rx source signals", {7'b0, int_n}, 8'h00);
        rread(0, v); chk("R10 ctrl readback", v, 8'h21);
        rread(3, v); chk("R8 port2 status", v, 8'h42);
        // global enable
        cyc(0, 1, 0, 8'h00, 0);
        cyc(0, 0, 0, 0, 24'h010000);
        chk("R7 disabled int_n high", {7'b0, int_n}, 8'h01);
        cyc(0, 1, 0, 8'h01, 0);
        chk("R7 enable asserts int", {7'b0, int_n}, 8'h00);
        rread(3, v); chk("R3 recorded while disabled", v, 8'h01);
        // event concurrent with clearing read
        cyc(0, 0, 0, 0, 24'h000001);
        cyc(1, 0, 1, 0, 24'h000004);
        chk("R5 read returns old", rdata, 8'h01);
        rread(1, v); chk("R5 concurrent event kept", v, 8'h04);
        // write to status ignored, map checks
        cyc(0, 1, 2, 8'hFF, 0);
        rread(2, v); chk("R10 status write ignored", v, 8'h00);
        rread(5, v); chk("R10 mask readback", v, 8'hFF);
        rread(7, v); chk("R11 unused address", v, 8'h00);
        cyc(0, 1, 0, 8'hFF, 0);
        rread(0, v); chk("R11 ctrl bits only", v, 8'h21);
        // random phase, compared on every clock by the model
        void'($urandom(32'd7));
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] e;
            e = $urandom & $urandom & $urandom;
            cyc(($urandom % 4) == 0, ($urandom % 8) == 0, 3'($urandom),
                8'($urandom), e);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule